// File: doc/BRIEF.md
# Synchronous Burst Read Port

This block is the device-side engine that streams 32-bit words out of a synchronous memory. A host pulls the active-low address strobe low for one rising clock edge, and the engine captures the word address and the latency code on that edge. It then counts out an initial access delay chosen by a 4-bit field of the control word. After the delay it presents one word per clock, advancing the address by one each cycle. The address wraps from the top of the 19-bit space back to zero.

The stream runs until the strobe is taken low again or reset is applied. A new strobe abandons the current stream and restarts with the full delay at the new address. Reset puts the port back into asynchronous mode, and it stays there until the next strobe. Output is always on the rising edge. The edge-select bit of the control word is accepted but does not change behaviour.

Behind the engine sits a small computed word store. Each word carries its own address in the low bits and a tag taken from a 64-entry array in the upper bits. This makes every delivered word identify where it came from.

Top module: `burst_read_port`

## Requirements
- R1: While `rst` is high on a rising edge, and after that until the next address strobe, `rvalid` is 0, `rdata` is 0 and `burst_mode` is 0.
- R2: A rising edge with `adv_n` low latches `addr` and `ctrl_cfg`. After that edge `burst_mode` is 1 and `rvalid` is 0.
- R3: Let the latch edge be edge 0 and let n be the value of `ctrl_cfg[13:10]`. The first word is presented after edge n+2 (2 to 9 cycles). Codes 8 to 15 give 9.
- R4: After the first word, one new word is presented after every rising edge. Its address is one higher than the previous word's, and 2^19-1 is followed by 0.
- R5: A word for address a has `rdata[18:0]` = a and `rdata[31:19]` = (37*(a mod 64)+5) mod 8192.
- R6: `rvalid` is 1 exactly on cycles that present a burst word. On every other cycle `rdata` is 0.
- R7: A strobe during the delay or during streaming abandons the current burst. A new burst starts at the new address with the full delay of the newly latched code.
- R8: `rst` high during a burst ends it on that edge: `rvalid` 0, `rdata` 0, `burst_mode` 0.
- R9: `ctrl_cfg[6]` has no effect on timing or data. `ctrl_cfg` changes after the latch edge do not alter the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst | input | 1 | Synchronous active-high reset; returns to asynchronous mode |
| adv_n | input | 1 | Active-low address strobe |
| addr | input | 19 | Start word address |
| ctrl_cfg | input | 16 | Control word; bits 13:10 latency code, bit 6 edge select |
| rdata | output | 32 | Burst word, zero when not valid |
| rvalid | output | 1 | High on cycles carrying a burst word |
| burst_mode | output | 1 | 1 in burst mode, 0 in asynchronous mode |

## Verification
The bench sweeps all sixteen latency codes, each from a different start address. For every code it checks the idle cycles before the first word and the first words themselves. This separates the n+2 decode from off-by-one errors and shows whether the clamp of codes 8 to 15 works. A start two words below the top of the address space tells correct wrapping apart from a stream that stops or runs past the top. Restrobes during the delay and during streaming show that the delay is reloaded in full. A reset mid-stream, followed by idle cycles, shows the drop to asynchronous mode and that the port stays there. Flipping the edge-select bit, and changing the latency field after the latch, must leave the stream identical.

// File: rtl/burst_read_pkg.sv
package burst_read_pkg;

    typedef enum logic [1:0] {
        PS_ASYNC  = 2'd0,
        PS_WAIT   = 2'd1,
        PS_STREAM = 2'd2
    } port_state_e;

    typedef struct packed {
        logic valid;
        logic mode;
    } port_flags_t;

    localparam int DEF_ADDR_W       = 19;
    localparam int DEF_DATA_W       = 32;
    localparam int DEF_CFG_W        = 16;
    localparam int DEF_LAT_LSB      = 10;
    localparam int DEF_LAT_W        = 4;
    localparam int DEF_LAT_BASE     = 2;
    localparam int DEF_LAT_MAX_CODE = 7;
    localparam int DEF_STORE_AW     = 6;

    // Tag stored in the word array for a given entry index.
    function automatic logic [31:0] fill_tag(input int unsigned idx);
        return 32'(idx * 32'd37 + 32'd5);
    endfunction

endpackage

// File: rtl/burst_lat_decode.sv
module burst_lat_decode #(
    parameter int LAT_W        = 4,
    parameter int LAT_BASE     = 2,
    parameter int LAT_MAX_CODE = 7,
    parameter int CNT_W        = 4
) (
    input  logic [LAT_W-1:0] lat_code,
    output logic [CNT_W-1:0] wait_init
);
    // Load value is the number of edges to wait minus one.
    always_comb begin
        if (int'(lat_code) > LAT_MAX_CODE)
            wait_init = CNT_W'(LAT_MAX_CODE + LAT_BASE - 1);
        else
            wait_init = CNT_W'(int'(lat_code) + LAT_BASE - 1);
    end
endmodule

// File: rtl/burst_word_store.sv
module burst_word_store
    import burst_read_pkg::*;
#(
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int DATA_W   = DEF_DATA_W,
    parameter int STORE_AW = DEF_STORE_AW
) (
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);
    localparam int TAG_W = DATA_W - ADDR_W;
    localparam int DEPTH = 1 << STORE_AW;

    logic [TAG_W-1:0] tag_mem [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_cell
            assign tag_mem[i] = TAG_W'(fill_tag(i));
        end
    endgenerate

    assign rd_word = {tag_mem[rd_addr[STORE_AW-1:0]], rd_addr};
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
    import burst_read_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [CNT_W-1:0]  wait_init,
    input  logic [DATA_W-1:0] fetch_word,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [DATA_W-1:0] rdata,
    output port_flags_t       flags
);
    port_state_e      state;
    logic [CNT_W-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= PS_ASYNC;
            wait_cnt    <= '0;
            fetch_addr  <= '0;
            rdata       <= '0;
            flags.valid <= 1'b0;
            flags.mode  <= 1'b0;
        end else if (!adv_n) begin
            state       <= PS_WAIT;
            wait_cnt    <= wait_init;
            fetch_addr  <= addr_in;
            rdata       <= '0;
            flags.valid <= 1'b0;
            flags.mode  <= 1'b1;
        end else begin
            unique case (state)
                PS_WAIT: begin
                    if (wait_cnt == '0) begin
                        rdata       <= fetch_word;
                        flags.valid <= 1'b1;
                        fetch_addr  <= fetch_addr + 1'b1;
                        state       <= PS_STREAM;
                    end else begin
                        wait_cnt <= wait_cnt - 1'b1;
                    end
                end
                PS_STREAM: begin
                    rdata      <= fetch_word;
                    fetch_addr <= fetch_addr + 1'b1;
                end
                default: begin
                    rdata       <= '0;
                    flags.valid <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/burst_read_port.sv
module burst_read_port
    import burst_read_pkg::*;
#(
    parameter int ADDR_W       = DEF_ADDR_W,
    parameter int DATA_W       = DEF_DATA_W,
    parameter int CFG_W        = DEF_CFG_W,
    parameter int LAT_LSB      = DEF_LAT_LSB,
    parameter int LAT_W        = DEF_LAT_W,
    parameter int LAT_BASE     = DEF_LAT_BASE,
    parameter int LAT_MAX_CODE = DEF_LAT_MAX_CODE,
    parameter int STORE_AW     = DEF_STORE_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CFG_W-1:0]  ctrl_cfg,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              burst_mode
);
    localparam int CNT_W = $clog2(LAT_MAX_CODE + LAT_BASE);

    logic [CNT_W-1:0]  wait_init;
    logic [ADDR_W-1:0] fetch_addr;
    logic [DATA_W-1:0] fetch_word;
    port_flags_t       flags;

    // Edge-select and other control bits have no effect here.
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{ctrl_cfg[CFG_W-1:LAT_LSB+LAT_W], ctrl_cfg[LAT_LSB-1:0]};

    burst_lat_decode #(
        .LAT_W(LAT_W), .LAT_BASE(LAT_BASE),
        .LAT_MAX_CODE(LAT_MAX_CODE), .CNT_W(CNT_W)
    ) u_dec (
        .lat_code (ctrl_cfg[LAT_LSB +: LAT_W]),
        .wait_init(wait_init)
    );

    burst_word_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STORE_AW(STORE_AW)
    ) u_store (
        .rd_addr(fetch_addr),
        .rd_word(fetch_word)
    );

    burst_seq_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .adv_n     (adv_n),
        .addr_in   (addr),
        .wait_init (wait_init),
        .fetch_word(fetch_word),
        .fetch_addr(fetch_addr),
        .rdata     (rdata),
        .flags     (flags)
    );

    assign rvalid     = flags.valid;
    assign burst_mode = flags.mode;
endmodule

// File: rtl/burst_read_chk.sv
module burst_read_chk #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              adv_n,
    input logic [DATA_W-1:0] rdata,
    input logic              rvalid,
    input logic              burst_mode
);
    logic seen_edge = 1'b0;
    always_ff @(posedge clk) seen_edge <= 1'b1;

    // R6
    rdata_zero_chk: assert property (@(posedge clk) disable iff (rst || !seen_edge)
        !rvalid |-> rdata == '0);

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        (seen_edge && $past(rst)) |-> (!rvalid && !burst_mode && rdata == '0));

    // R2
    latch_mode_chk: assert property (@(posedge clk) disable iff (rst || !seen_edge)
        !adv_n |=> (burst_mode && !rvalid));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (rst || !seen_edge)
        (rvalid && $past(rvalid)) |-> rdata[ADDR_W-1:0] == $past(rdata[ADDR_W-1:0]) + 1'b1);

    // R1
    mode_rise_chk: assert property (@(posedge clk) disable iff (rst || !seen_edge)
        $rose(burst_mode) |-> $past(!adv_n));

    // R6
    valid_mode_chk: assert property (@(posedge clk) disable iff (rst || !seen_edge)
        rvalid |-> burst_mode);
endmodule

bind burst_read_port burst_read_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .adv_n(adv_n), .rdata(rdata),
    .rvalid(rvalid), .burst_mode(burst_mode)
);

// File: tb/tb_burst_read_port.sv
module tb_burst_read_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adv_n = 1'b1;
    logic [18:0] addr = '0;
    logic [15:0] ctrl_cfg = 16'h0040;
    logic [31:0] rdata;
    logic        rvalid;
    logic        burst_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    burst_read_port dut (
        .clk(clk), .rst(rst), .adv_n(adv_n), .addr(addr),
        .ctrl_cfg(ctrl_cfg), .rdata(rdata), .rvalid(rvalid),
        .burst_mode(burst_mode)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] exp_word(input logic [18:0] a);
        int unsigned t;
        t = (37 * int'(a[5:0]) + 5) % 8192;
        return {t[12:0], a};
    endfunction

    function automatic int exp_lat(input int code);
        return ((code > 7) ? 7 : code) + 2;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Latch a burst, then check 'span' cycles after the latch edge.
    task automatic run_burst(input logic [18:0] a, input int code, input bit b6,
                             input int span, input bit late_cfg, input string req);
        int lat;
        lat = exp_lat(code);
        @(negedge clk);
        adv_n = 1'b0;
        addr = a;
        ctrl_cfg = 16'h0;
        ctrl_cfg[13:10] = 4'(code);
        ctrl_cfg[6] = b6;
        @(negedge clk);
        adv_n = 1'b1;
        addr = ~a;
        if (late_cfg) ctrl_cfg = ~ctrl_cfg;
        chk(burst_mode == 1'b1 && rvalid == 1'b0, {"R2 ", req}, {30'd0, burst_mode, rvalid}, 32'd2);
        for (int k = 1; k <= span; k++) begin
            @(negedge clk);
            if (k < lat)
                chk(rvalid == 1'b0 && rdata == '0, {"R3/R6 ", req}, rdata, 32'd0);
            else
                chk(rvalid == 1'b1 && rdata == exp_word(a + 19'(k - lat)),
                    {"R3/R4/R5 ", req}, rdata, exp_word(a + 19'(k - lat)));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rvalid == 1'b0 && rdata == '0 && burst_mode == 1'b0, "R1 reset", {rdata[29:0], rvalid, burst_mode}, 32'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(rvalid == 1'b0 && burst_mode == 1'b0, "R1 idle", {30'd0, rvalid, burst_mode}, 32'd0);

        // R3 latency sweep over all codes
        for (int c = 0; c < 16; c++)
            run_burst(19'((c * 32771 + 7) & 19'h7FFFF), c, 1'b1, exp_lat(c) + 3, 1'b0, "R3 sweep");

        // R9 edge-select bit and late cfg change
        run_burst(19'h01234, 2, 1'b0, 7, 1'b0, "R9 bit6");
        run_burst(19'h05555, 0, 1'b1, 6, 1'b1, "R9 late cfg");

        // R4 wrap
        run_burst(19'h7FFFE, 1, 1'b1, 3 + 4, 1'b0, "R4 wrap");

        // R7 restrobe while streaming, then while waiting
        run_burst(19'h00100, 1, 1'b1, 5, 1'b0, "R7 first");
        run_burst(19'h00200, 3, 1'b1, 3, 1'b0, "R7 mid-stream");
        run_burst(19'h00300, 0, 1'b1, 5, 1'b0, "R7 mid-wait");

        // R8 reset mid-burst, then R1 stays asynchronous
        run_burst(19'h04000, 4, 1'b1, 8, 1'b0, "R8 pre");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(rvalid == 1'b0 && rdata == '0 && burst_mode == 1'b0, "R8 abort", {rdata[29:0], rvalid, burst_mode}, 32'd0);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(rvalid == 1'b0 && rdata == '0 && burst_mode == 1'b0, "R1 after reset", {rdata[29:0], rvalid, burst_mode}, 32'd0);
        end
        run_burst(19'h00040, 0, 1'b1, 4, 1'b0, "R2 after reset");

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule